// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Stop and Single-Step

This block paces a processor that talks to its program store over a narrow nibble bus. It splits the main clock into machine cycles of a fixed length and counts the clocks of each cycle with a phase index. It gives a one-hot strobe for every phase and a sync pulse on the last clock. In every working cycle it drives a 12-bit instruction address onto the 4-bit bus, one nibble per clock over the first three clocks. Two fetch clocks follow, in which the bus is not driven. The remaining clocks of the cycle carry an execute enable for the datapath.

A stop input lets a debugger or an I/O controller park the processor. When parked, the processor stops executing and releases the bus. The phase counter, strobes and sync keep running, so that interrupt and peripheral logic outside stays locked to the cycle grid. Stop is honoured only at an instruction boundary, never in the middle of a two-cycle instruction. If the stop input is released for a single boundary, exactly one instruction runs, which gives single-stepping.

Top module: `mcs_sequencer`

## Requirements
- R1: The phase index counts 0,1,...,7 and wraps to 0, one step per clock. `phase_strb` has exactly bit `phase` set. `sync` is high only while the phase is 7.
- R2: Reset is synchronous and active high. While it is held and on the first clock after it, the phase is 0, `stop_ack` is low and the cycle is an active first cycle.
- R3: In an active cycle, phases 0, 1 and 2 put address bits [3:0], [7:4] and [11:8] on `addr_nib` with `bus_en` high. The address is the value of `pc_in` captured on the clock that ends the preceding cycle, and it is 0 after reset. In every other phase, and in idle cycles, `bus_en` is low and `addr_nib` is 0.
- R4: `exec_en` is high in phases 5, 6 and 7 of active cycles and low in every other phase.
- R5: `stop_req` and `two_cyc` are sampled only on the clock that ends a cycle (phase 7). Their values in phases 0 to 6 have no effect on any output.
- R6: If `two_cyc` is high at the end of a first cycle, the next cycle is the second cycle of the same instruction and is active even when `stop_req` is high. `two_cyc` is ignored at the end of a second cycle or an idle cycle.
- R7: `stop_ack` rises at phase 0 of the first idle cycle and stays high while `stop_req` is sampled high. It falls at phase 0 of the cycle that follows a boundary at which `stop_req` was sampled low. It never changes in phases 1 to 7.
- R8: While `stop_ack` is high, the phase, strobes and sync keep running, and `bus_en` and `exec_en` stay low.
- R9: Dropping `stop_req` for one boundary and raising it again runs exactly one instruction (one cycle, or two if `two_cyc` is flagged), after which the sequencer returns to idle.
- R10: Reset asserted in the middle of any cycle, active or idle, returns the sequencer to the R2 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to park the processor, sampled at phase 7 |
| two_cyc | input | 1 | Decoder flag: current instruction needs a second cycle |
| pc_in | input | 12 | Address of the next instruction word |
| phase | output | 3 | Clock index within the machine cycle |
| phase_strb | output | 8 | One-hot phase strobes |
| sync | output | 1 | High on the last clock of each cycle |
| addr_nib | output | 4 | Address nibble driven onto the bus |
| bus_en | output | 1 | Bus driver enable |
| exec_en | output | 1 | Datapath execute enable |
| stop_ack | output | 1 | Processor is parked |

## Verification
The critical overlap is a stop request and a two-cycle flag sampled on the same boundary. The second cycle must still run, and the stop must be taken one cycle later. The bench sweeps every 4-cycle sequence of the two inputs at boundaries. It drives the inverted values in all other phases, so any sampling off the boundary or any split of an instruction shows up. A reference model built from the requirements judges `stop_ack`, `bus_en` and `exec_en` clock by clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    // Control state of the machine cycle now in progress
    typedef enum logic [1:0] {
        RS_FIRST  = 2'd0,
        RS_SECOND = 2'd1,
        RS_IDLE   = 2'd2
    } run_st_e;

    // Role of one clock within a machine cycle
    typedef enum logic [1:0] {
        SK_ADDR  = 2'd0,
        SK_FETCH = 2'd1,
        SK_EXEC  = 2'd2
    } sub_kind_e;

    // What the rest of the block needs to know about the run state
    typedef struct packed {
        logic active;
        logic halted;
    } run_view_t;

    function automatic sub_kind_e classify(input int unsigned ph,
                                           input int unsigned n_addr,
                                           input int unsigned n_fetch);
        if (ph < n_addr)
            return SK_ADDR;
        else if (ph < n_addr + n_fetch)
            return SK_FETCH;
        else
            return SK_EXEC;
    endfunction

endpackage

// File: rtl/mcs_phase_gen.sv
module mcs_phase_gen #(
    parameter  int CYC_LEN = 8,
    localparam int PH_W    = $clog2(CYC_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PH_W-1:0]    phase,
    output logic [CYC_LEN-1:0] strobe,
    output logic               last
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (phase == PH_LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    for (genvar g = 0; g < CYC_LEN; g++) begin : g_strb
        assign strobe[g] = (phase == PH_W'(g));
    end

    assign last = (phase == PH_LAST);
endmodule

// File: rtl/mcs_run_ctrl.sv
module mcs_run_ctrl
    import mcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cyc_end,
    input  logic      stop_req,
    input  logic      two_cyc,
    output run_view_t view
);
    run_st_e st, st_nx;

    always_comb begin
        st_nx = st;
        if (cyc_end) begin
            unique case (st)
                RS_FIRST:
                    if (two_cyc)
                        st_nx = RS_SECOND;
                    else
                        st_nx = stop_req ? RS_IDLE : RS_FIRST;
                RS_SECOND:
                    st_nx = stop_req ? RS_IDLE : RS_FIRST;
                default:
                    st_nx = stop_req ? RS_IDLE : RS_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= RS_FIRST;
        else
            st <= st_nx;
    end

    assign view.active = (st != RS_IDLE);
    assign view.halted = (st == RS_IDLE);
endmodule

// File: rtl/mcs_addr_mux.sv
module mcs_addr_mux #(
    parameter  int ADDR_W = 12,
    parameter  int NIB_W  = 4,
    parameter  int PH_W   = 3,
    localparam int N_NIB  = ADDR_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [PH_W-1:0]   phase,
    input  logic              drive,
    output logic [NIB_W-1:0]  nib
);
    logic [ADDR_W-1:0] addr_q;
    logic [NIB_W-1:0]  slice [N_NIB];

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= pc_in;
    end

    for (genvar g = 0; g < N_NIB; g++) begin : g_slice
        assign slice[g] = addr_q[g*NIB_W +: NIB_W];
    end

    always_comb begin
        nib = '0;
        if (drive) begin
            for (int k = 0; k < N_NIB; k++) begin
                if (phase == PH_W'(k))
                    nib = slice[k];
            end
        end
    end
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
    import mcs_pkg::*;
#(
    parameter  int CYC_LEN    = 8,
    parameter  int ADDR_W     = 12,
    parameter  int NIB_W      = 4,
    parameter  int FETCH_SUBS = 2,
    localparam int PH_W       = $clog2(CYC_LEN),
    localparam int N_NIB      = ADDR_W / NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_req,
    input  logic               two_cyc,
    input  logic [ADDR_W-1:0]  pc_in,
    output logic [PH_W-1:0]    phase,
    output logic [CYC_LEN-1:0] phase_strb,
    output logic               sync,
    output logic [NIB_W-1:0]   addr_nib,
    output logic               bus_en,
    output logic               exec_en,
    output logic               stop_ack
);
    logic      cyc_end;
    run_view_t view;
    sub_kind_e kind;

    mcs_phase_gen #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .strobe (phase_strb),
        .last   (cyc_end)
    );

    mcs_run_ctrl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cyc_end  (cyc_end),
        .stop_req (stop_req),
        .two_cyc  (two_cyc),
        .view     (view)
    );

    always_comb kind = classify(int'(phase), N_NIB, FETCH_SUBS);

    assign bus_en   = view.active && (kind == SK_ADDR);
    assign exec_en  = view.active && (kind == SK_EXEC);
    assign stop_ack = view.halted;
    assign sync     = cyc_end;

    mcs_addr_mux #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .PH_W(PH_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .load  (cyc_end),
        .pc_in (pc_in),
        .phase (phase),
        .drive (bus_en),
        .nib   (addr_nib)
    );
endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk #(
    parameter int CYC_LEN = 8,
    parameter int PH_W    = 3,
    parameter int N_NIB   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               two_cyc,
    input logic [PH_W-1:0]    phase,
    input logic [CYC_LEN-1:0] phase_strb,
    input logic               sync,
    input logic               bus_en,
    input logic               exec_en,
    input logic               stop_ack
);
    localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

    // Tracks whether the current cycle is the second half of a pair
    logic sec_q;
    always_ff @(posedge clk) begin
        if (rst)
            sec_q <= 1'b0;
        else if (phase == LAST)
            sec_q <= !stop_ack && !sec_q && two_cyc;
    end

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));

    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == PH_W'($past(phase) + 1'b1)));

    p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        ($countones(phase_strb) == 1) && phase_strb[phase]);

    p_sync_last_r1: assert property (@(posedge clk) disable iff (rst)
        sync |=> (phase == '0));

    p_bus_window_r3: assert property (@(posedge clk) disable iff (rst)
        bus_en |-> (int'(phase) < N_NIB));

    p_ack_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> $stable(stop_ack));

    p_ack_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_ack) |-> (phase == '0));

    p_quiet_stop_r8: assert property (@(posedge clk) disable iff (rst)
        stop_ack |-> (!bus_en && !exec_en));

    p_no_split_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST && !stop_ack && !sec_q && two_cyc) |=> !stop_ack);
endmodule

bind mcs_sequencer mcs_sequencer_chk #(
    .CYC_LEN (CYC_LEN),
    .PH_W    (PH_W),
    .N_NIB   (N_NIB)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .two_cyc    (two_cyc),
    .phase      (phase),
    .phase_strb (phase_strb),
    .sync       (sync),
    .bus_en     (bus_en),
    .exec_en    (exec_en),
    .stop_ack   (stop_ack)
);

// File: tb/sim_mcs_sequencer.sv
module sim_mcs_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_req = 1'b0;
    logic        two_cyc = 1'b0;
    logic [11:0] pc_in = '0;
    logic [2:0]  phase;
    logic [7:0]  phase_strb;
    logic        sync;
    logic [3:0]  addr_nib;
    logic        bus_en;
    logic        exec_en;
    logic        stop_ack;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mcs_sequencer u0 (
        .clk(clk), .rst(rst), .stop_req(stop_req), .two_cyc(two_cyc),
        .pc_in(pc_in), .phase(phase), .phase_strb(phase_strb), .sync(sync),
        .addr_nib(addr_nib), .bus_en(bus_en), .exec_en(exec_en),
        .stop_ack(stop_ack)
    );

    // Reference model from the requirements: 0 first, 1 second, 2 idle
    int          m_ph   = 0;
    int          m_st   = 0;
    logic [11:0] m_addr = '0;
    string       m_why  = "R2";

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_st <= 0; m_addr <= '0; m_why <= "R10";
        end else begin
            m_ph <= (m_ph + 1) % 8;
            if (m_ph == 7) begin
                m_addr <= pc_in;
                if (m_st == 0 && two_cyc) begin
                    m_st <= 1; m_why <= stop_req ? "R6" : "R5";
                end else if (stop_req) begin
                    m_st <= 2; m_why <= "R7";
                end else begin
                    m_st <= 0; m_why <= (m_st == 2) ? "R9" : "R5";
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic act_on;
        logic [3:0] e_nib;
        act_on = (m_st != 2);
        e_nib  = (act_on && m_ph < 3) ? m_addr[m_ph*4 +: 4] : 4'h0;
        chk(phase == 3'(m_ph), "R1 phase", int'(phase), m_ph);
        chk(phase_strb == 8'(1 << m_ph), "R1 strobe", int'(phase_strb), 1 << m_ph);
        chk(sync == (m_ph == 7), "R1 sync", int'(sync), int'(m_ph == 7));
        chk(bus_en == (act_on && m_ph < 3), "R3 bus_en", int'(bus_en), int'(act_on && m_ph < 3));
        chk(addr_nib == e_nib, "R3 addr_nib", int'(addr_nib), int'(e_nib));
        chk(exec_en == (act_on && m_ph >= 5), "R4 exec_en", int'(exec_en), int'(act_on && m_ph >= 5));
        if (m_ph == 0)
            chk(stop_ack == !act_on, {m_why, " stop_ack at boundary"}, int'(stop_ack), int'(!act_on));
        else
            chk(stop_ack == !act_on, "R7 stop_ack", int'(stop_ack), int'(!act_on));
        if (!act_on)
            chk(!bus_en && !exec_en, "R8 quiet while stopped", int'({bus_en, exec_en}), 0);
    endtask

    // Drive true values only for the sampling clock, inverted noise otherwise (R5)
    task automatic drive(input bit s, input bit t, input int k);
        pc_in = 12'(k * 37 + 291);
        if (m_ph == 7) begin
            stop_req = s; two_cyc = t;
        end else begin
            stop_req = !s; two_cyc = !t;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R2: state during and right after reset
        chk(phase == 3'd0 && stop_ack == 1'b0, "R2 reset state", int'({phase, stop_ack}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(phase == 3'd1 && !stop_ack, "R2 first step after reset", int'({phase, stop_ack}), 2);
        // Near-exhaustive sweep: every 4-cycle sequence of (stop_req, two_cyc)
        for (int s = 0; s < 256; s++) begin
            for (int j = 0; j < 4; j++) begin
                for (int p = 0; p < 8; p++) begin
                    bit sr;
                    bit tc;
                    sr = 1'((s >> (2 * j + 1)) & 1);
                    tc = 1'((s >> (2 * j)) & 1);
                    drive(sr, tc, s * 32 + j * 8 + p);
                    @(negedge clk);
                    check_all();
                end
            end
        end
        // R10: reset in the middle of an idle and of an active cycle
        for (int r = 0; r < 2; r++) begin
            stop_req = (r == 0); two_cyc = 1'b0;
            repeat (19) begin
                @(negedge clk);
                check_all();
            end
            rst = 1'b1;
            @(negedge clk);
            chk(phase == 3'd0 && !stop_ack, "R10 mid-run reset", int'({phase, stop_ack}), 0);
            rst = 1'b0; stop_req = 1'b0;
            repeat (10) begin
                @(negedge clk);
                check_all();
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule